// File: doc/BRIEF.md
# I2C Master SCL Clock Divider

This block produces the serial clock for an I2C master from the module clock. A programmable prescaler first divides the module clock by (prescale + 1) to make a tick. The SCL low phase then lasts (low count + k) ticks and the high phase lasts (high count + k) ticks. The fixed offset k depends on the prescale value: 7 when it is 0, 6 when it is 1, and 5 for any larger value. One full SCL period is therefore (prescale+1) × ((low + k) + (high + k)) module clock cycles. With a module clock of 7 to 12 MHz after the prescaler, this gives the usual bus rates.

The divider configuration is captured only while the module enable is low. While the module is enabled, the captured values are frozen. The master protocol engine raises a run request while a transfer is in progress. Each new request starts the waveform with a fresh, full low phase. When the request or the enable drops, SCL is released. Two single-cycle strobes tell the engine where to act on SDA: a change strobe on the first cycle of every low phase, and a sample strobe in the middle of every high phase.

Top module: `scl_clk_gen`

## Requirements
- R1: While `mod_en` is 0, and after reset, `scl_low_o`, `chg_stb_o` and `smp_stb_o` are 0 from the cycle after the edge that samples it.
- R2: With `mod_en` 1 and `run_req` 0, SCL stays released (`scl_low_o` = 0) and no strobe fires.
- R3: The phase counters advance once every (P+1) module clock cycles, where P is the captured prescale value. The SCL period is (P+1)·((L+k)+(H+k)) cycles.
- R4: The offset k is 7 for P = 0, 6 for P = 1, and 5 for P ≥ 2.
- R5: `scl_low_o` is 1 for exactly (P+1)·(L+k) consecutive cycles, then 0 for exactly (P+1)·(H+k) cycles, repeating while running.
- R6: The cycle after an edge that samples `mod_en`=1 and `run_req`=1 while idle begins a full low phase (`scl_low_o`=1, `chg_stb_o`=1). This holds also after a one-cycle drop of `run_req`.
- R7: `chg_stb_o` is 1 for exactly one cycle: the first cycle of every low phase.
- R8: `smp_stb_o` is 1 for exactly one cycle in each high phase, (P+1)·floor((H+k)/2) cycles after the high phase begins. It is never 1 while `scl_low_o` is 1.
- R9: `psc_i`, `low_i` and `high_i` are captured on every edge where `mod_en` is 0. Changes to them while `mod_en` is 1 have no effect on the waveform.
- R10: Low and high counts of 0 are legal and give phases of exactly k ticks.
- R11: When `run_req` drops while running, SCL is released and the strobes stop from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Module enable; 0 holds the divider idle and loads the configuration |
| run_req | input | 1 | Run request from the master protocol engine |
| psc_i | input | PSC_W | Prescale value P |
| low_i | input | CNT_W | Low count L |
| high_i | input | CNT_W | High count H |
| scl_low_o | output | 1 | 1 drives SCL low, 0 releases it |
| chg_stb_o | output | 1 | One-cycle strobe at the start of each low phase (SDA may change) |
| smp_stb_o | output | 1 | One-cycle strobe in the middle of each high phase (SDA sample point) |

## Verification
All outputs come from registers. A change on `mod_en` or `run_req` shows up one cycle after the rising edge that samples it. After that, the SCL and strobe timing follows the count of module clock cycles since the run started. The bench has a reference model that keeps a single cycle index within the SCL period and derives every output from the closed-form phase lengths. The model updates on the same rising edge as the design. The bench compares all three outputs on every falling edge, so each result is checked in the cycle it is due, including during stops, restarts and configuration changes made while enabled.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Fixed extra ticks added to each SCL phase, chosen by the prescale value.
  function automatic logic [3:0] extra_ticks(input logic [31:0] p);
    if (p == 32'd0)      return 4'd7;
    else if (p == 32'd1) return 4'd6;
    else                 return 4'd5;
  endfunction

endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic [CNT_W-1:0] high_i,
  output logic [PSC_W-1:0] psc_q,
  output logic [CNT_W-1:0] low_q,
  output logic [CNT_W-1:0] high_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (load) begin
      psc_q  <= psc_i;
      low_q  <= low_i;
      high_q <= high_i;
    end
  end

  // R9: configuration frozen while not loading
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(psc_q) && $stable(low_q) && $stable(high_q)));

endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick
);

  logic [PSC_W-1:0] pc_q;

  assign tick = (pc_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (hold) pc_q <= '0;
    else if (tick) pc_q <= '0;
    else           pc_q <= pc_q + PSC_W'(1);
  end

  // R3: the prescale count never passes the divide value
  a_r3_pc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= div_i);

endmodule

// File: rtl/scl_phase.sv
module scl_phase
  import scl_div_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  output logic             active,
  output logic             scl_low,
  output logic             chg_stb,
  output logic             smp_stb
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  phase_e           st_q;
  logic [LEN_W-1:0] ph_q;
  logic             chg_q;
  logic             smp_q;
  logic             low_end;
  logic             high_end;
  logic [LEN_W-1:0] ph_inc;
  logic [LEN_W-1:0] mid_pt;

  assign ph_inc   = ph_q + ONE;
  assign mid_pt   = high_len >> 1;
  assign low_end  = tick && (ph_q == low_len - ONE);
  assign high_end = tick && (ph_q == high_len - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      ph_q  <= '0;
      chg_q <= 1'b0;
      smp_q <= 1'b0;
    end else if (!go) begin
      st_q  <= PH_IDLE;
      ph_q  <= '0;
      chg_q <= 1'b0;
      smp_q <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      smp_q <= 1'b0;
      unique case (st_q)
        PH_IDLE: begin
          st_q  <= PH_LOW;
          ph_q  <= '0;
          chg_q <= 1'b1;
        end
        PH_LOW: begin
          if (low_end) begin
            st_q <= PH_HIGH;
            ph_q <= '0;
          end else if (tick) begin
            ph_q <= ph_inc;
          end
        end
        PH_HIGH: begin
          if (high_end) begin
            st_q  <= PH_LOW;
            ph_q  <= '0;
            chg_q <= 1'b1;
          end else if (tick) begin
            ph_q  <= ph_inc;
            smp_q <= (ph_inc == mid_pt);
          end
        end
        default: begin
          st_q <= PH_IDLE;
          ph_q <= '0;
        end
      endcase
    end
  end

  assign active  = (st_q != PH_IDLE);
  assign scl_low = (st_q == PH_LOW);
  assign chg_stb = chg_q;
  assign smp_stb = smp_q;

  // R11: a dropped request releases SCL and silences the strobes
  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!scl_low && !chg_stb && !smp_stb));

  // R6: a request seen while idle opens a fresh low phase
  a_r6_fresh_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && go) |=> (scl_low && chg_stb));

  // R7: the two strobes never coincide
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_stb && smp_stb));

  // R8: sample strobe only inside a high phase
  a_r8_smp_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (active && !scl_low));

  // R3: without a prescaler tick the phase position holds
  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active && go && !tick) |=> ($stable(ph_q) && $stable(st_q)));

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
  import scl_div_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             run_req,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic [CNT_W-1:0] high_i,
  output logic             scl_low_o,
  output logic             chg_stb_o,
  output logic             smp_stb_o
);

  localparam int LEN_W = CNT_W + 1;

  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] low_q;
  logic [CNT_W-1:0] high_q;
  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] high_len;
  logic [LEN_W-1:0] k_ext;
  logic             go;
  logic             active;
  logic             tick;
  logic             pre_hold;

  assign go       = mod_en && run_req;
  assign pre_hold = !(go && active);
  assign k_ext    = LEN_W'(extra_ticks(32'(psc_q)));
  assign low_len  = LEN_W'(low_q) + k_ext;
  assign high_len = LEN_W'(high_q) + k_ext;

  scl_cfg_shadow #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (!mod_en),
    .psc_i  (psc_i),
    .low_i  (low_i),
    .high_i (high_i),
    .psc_q  (psc_q),
    .low_q  (low_q),
    .high_q (high_q)
  );

  scl_prescale #(.PSC_W(PSC_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (pre_hold),
    .div_i (psc_q),
    .tick  (tick)
  );

  scl_phase #(.LEN_W(LEN_W)) u_ph (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .tick     (tick),
    .low_len  (low_len),
    .high_len (high_len),
    .active   (active),
    .scl_low  (scl_low_o),
    .chg_stb  (chg_stb_o),
    .smp_stb  (smp_stb_o)
  );

  // R1: disabling the module releases SCL on the next cycle
  a_r1_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (!scl_low_o && !chg_stb_o && !smp_stb_o));

  // R4: the phase lengths never drop below the smallest offset
  a_r4_min_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (low_len >= LEN_W'(5)) && (high_len >= LEN_W'(5)));

endmodule

// File: tb/scl_clk_gen_tb.sv
module scl_clk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mod_en = 1'b0;
  logic       run_req = 1'b0;
  logic [7:0] psc_i = '0;
  logic [7:0] low_i = '0;
  logic [7:0] high_i = '0;
  logic       scl_low_o, chg_stb_o, smp_stb_o;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  scl_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .run_req(run_req),
    .psc_i(psc_i), .low_i(low_i), .high_i(high_i),
    .scl_low_o(scl_low_o), .chg_stb_o(chg_stb_o), .smp_stb_o(smp_stb_o)
  );

  // Reference model: one cycle index within the SCL period.
  int m_act = 0, m_t = 0, s_p = 0, s_l = 0, s_h = 0;

  function automatic int k_of(int p);
    return (p == 0) ? 7 : ((p == 1) ? 6 : 5);
  endfunction
  function automatic int low_cyc();
    return (s_p + 1) * (s_l + k_of(s_p));
  endfunction
  function automatic int period();
    return low_cyc() + (s_p + 1) * (s_h + k_of(s_p));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; s_p = 0; s_l = 0; s_h = 0;
    end else if (!mod_en) begin
      m_act = 0; m_t = 0;
      s_p = int'(psc_i); s_l = int'(low_i); s_h = int'(high_i);
    end else if (!run_req) begin
      m_act = 0; m_t = 0;
    end else if (m_act == 0) begin
      m_act = 1; m_t = 0;
    end else begin
      m_t = (m_t + 1) % period();
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic e_low, e_chg, e_smp;
      e_low = (m_act != 0) && (m_t < low_cyc());
      e_chg = (m_act != 0) && (m_t == 0);
      e_smp = (m_act != 0) &&
              (m_t == low_cyc() + (s_p + 1) * ((s_h + k_of(s_p)) / 2));
      checks++;
      if ({scl_low_o, chg_stb_o, smp_stb_o} !== {e_low, e_chg, e_smp}) begin
        errors++;
        $display("FAIL %s t=%0t {scl_low,chg,smp} actual=%b%b%b expected=%b%b%b",
                 tag, $time, scl_low_o, chg_stb_o, smp_stb_o, e_low, e_chg, e_smp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int p, int l, int h);
    mod_en = 1'b0; run_req = 1'b0;
    psc_i = 8'(p); low_i = 8'(l); high_i = 8'(h);
    step(2);
    mod_en = 1'b1;
  endtask

  initial begin
    tag = "R1 reset";
    step(4);
    rst_n = 1'b1;
    step(3);
    // R10 and R4: zero counts, P=0 gives 7-tick phases
    tag = "R10";
    cfg(0, 0, 0);
    run_req = 1'b1; step(60);
    // R11: stop while running
    tag = "R11";
    run_req = 1'b0; step(6);
    // R4: P=1 offset 6
    tag = "R4";
    cfg(1, 3, 2);
    run_req = 1'b1; step(100);
    // R5: phase lengths with P=3
    tag = "R5";
    cfg(3, 2, 4);
    run_req = 1'b1; step(200);
    // R8: sample strobe placement with odd high length
    tag = "R8";
    cfg(2, 1, 6);
    run_req = 1'b1; step(150);
    // R9: configuration changes while enabled are ignored
    tag = "R9";
    psc_i = 8'd0; low_i = 8'd9; high_i = 8'd1;
    step(150);
    // R6: one-cycle request drop restarts with a full low phase
    tag = "R6";
    step(7);
    run_req = 1'b0; step(1);
    run_req = 1'b1; step(80);
    // R7: change strobe each low phase
    tag = "R7";
    cfg(0, 5, 3);
    run_req = 1'b1; step(100);
    // R3: large prescale stretches every tick
    tag = "R3";
    cfg(9, 0, 0);
    run_req = 1'b1; step(300);
    // R2: enabled but no request
    tag = "R2";
    run_req = 1'b0; step(20);
    // R1: disabled with request present
    tag = "R1";
    mod_en = 1'b0; run_req = 1'b1; step(20);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=running expected=finished", tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule